// File: doc/BRIEF.md
# Barrel Thread Issue Selector

This block decides, on every clock, which hardware thread context may place one instruction into a pipeline that all threads share. It keeps a small status record for each thread. A thread is ready when it may issue. It is in flight while its one instruction is still travelling down the pipeline. It is parked while that instruction waits for memory. Only ready threads take part in selection. Issuing an instruction takes a thread out of the ready pool, so no thread ever has two instructions in the pipeline at once.

The selector offers a thread number and a valid flag to the issue stage, and that stage answers with an accept. The pipeline reports completions through a pulse vector with one bit per thread. A memory miss is reported by a park request on the in-flight thread, and the memory system later sends a return pulse for it. The search for the next ready thread starts one position after the thread that last issued and wraps around, so ready threads take turns fairly. When no thread is ready, the valid flag drops and the pipeline receives a bubble. With the thread count equal to the pipeline depth and every completion arriving on time, each thread issues once per revolution.

Top module: `barrel_sel`

## Requirements
- R1: A thread whose offer is accepted (sel_valid and issue_ack both high) is not offered again until its completion pulse has been seen.
- R2: sel_valid is high exactly when at least one thread is ready, and the offered thread is always a ready one. With no ready thread, sel_valid is low and the cycle is a bubble.
- R3: The search order is circular by thread number. It begins at the thread one above the last accepted thread, and thread N-1 wraps to thread 0.
- R4: The search start moves only on an accepted offer. An offer that is not accepted is repeated unchanged on the next cycle, and issue_ack while sel_valid is low has no effect.
- R5: A park request (park_req bit i) on an in-flight thread moves it to the parked state, and the thread is then never offered. A completion pulse for a parked thread is ignored, and only a memory return (mem_ret bit i) makes it ready again. If a park request and a completion reach the same thread in one cycle, the park request wins. A park request for a thread that is ready is ignored.
- R6: A completion pulse or a memory return takes effect at the next clock edge. In the cycle the pulse arrives, the thread is not yet selectable.
- R7: After reset, all threads are ready and the first offer is thread 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised internally |
| issue_ack | input | 1 | The issue stage takes the offered thread this cycle |
| done_pulse | input | NTHREADS | One bit per thread: its in-flight instruction has completed |
| park_req | input | NTHREADS | One bit per thread: its in-flight instruction now waits on memory |
| mem_ret | input | NTHREADS | One bit per thread: the awaited memory data has returned |
| sel_valid | output | 1 | An offer is present this cycle |
| sel_tid | output | $clog2(NTHREADS) | Thread number offered |

## Verification
The assertions check the invariants on every cycle. They confirm that an offer is always a ready thread, that no bubble occurs while some thread is ready, and that an accepted thread is not offered again on the next cycle. They also check that the search start moves exactly to the thread after an accepted one and otherwise holds, and that a parked thread stays parked and unoffered until its memory return. Whole orderings can only be shown by the bench's directed scenarios: a full revolution followed by a bubble, a pointer wrap, completions and returns that open up selection one cycle late, a park request winning over a same-cycle completion, and park requests on ready threads that change nothing.

// File: rtl/barrel_pkg.sv
package barrel_pkg;
  typedef enum logic [1:0] {
    TS_READY  = 2'b00,
    TS_FLIGHT = 2'b01,
    TS_PARKED = 2'b10
  } tstate_e;
endpackage

// File: rtl/barrel_rst_sync.sv
module barrel_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/barrel_slot.sv
module barrel_slot
  import barrel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic issue_hit,
  input  logic done_in,
  input  logic park_in,
  input  logic ret_in,
  output logic is_ready,
  output logic is_parked
);
  tstate_e st_q, st_d;
  logic    st_en;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      TS_READY:  if (issue_hit) st_d = TS_FLIGHT;
      TS_FLIGHT: begin
        if (park_in)      st_d = TS_PARKED;
        else if (done_in) st_d = TS_READY;
      end
      TS_PARKED: if (ret_in) st_d = TS_READY;
      default:   st_d = TS_READY;
    endcase
  end

  assign st_en = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= TS_READY;
    else if (st_en) st_q <= st_d;
  end

  assign is_ready  = (st_q == TS_READY);
  assign is_parked = (st_q == TS_PARKED);
endmodule

// File: rtl/barrel_pick.sv
module barrel_pick #(
  parameter int N     = 8,
  parameter int TID_W = 3
) (
  input  logic [N-1:0]     elig,
  input  logic [TID_W-1:0] start,
  output logic             found,
  output logic [TID_W-1:0] pick
);
  int idx;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    idx   = 0;
    for (int k = 0; k < N; k++) begin
      idx = int'(start) + k;
      if (idx >= N) idx = idx - N;
      if (!found && elig[idx]) begin
        found = 1'b1;
        pick  = TID_W'(idx);
      end
    end
  end
endmodule

// File: rtl/barrel_sel.sv
module barrel_sel #(
  parameter int NTHREADS = 8,
  localparam int TID_W = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issue_ack,
  input  logic [NTHREADS-1:0] done_pulse,
  input  logic [NTHREADS-1:0] park_req,
  input  logic [NTHREADS-1:0] mem_ret,
  output logic                sel_valid,
  output logic [TID_W-1:0]    sel_tid
);
  localparam logic [TID_W-1:0] LAST_TID = TID_W'(NTHREADS - 1);

  logic                rst_core_n;
  logic [NTHREADS-1:0] ready_vec;
  logic [NTHREADS-1:0] park_vec;
  logic                take;
  logic [TID_W-1:0]    start_q, start_d;

  barrel_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign take = sel_valid & issue_ack;

  for (genvar g = 0; g < NTHREADS; g++) begin : g_slot
    barrel_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .issue_hit (take && (sel_tid == TID_W'(g))),
      .done_in   (done_pulse[g]),
      .park_in   (park_req[g]),
      .ret_in    (mem_ret[g]),
      .is_ready  (ready_vec[g]),
      .is_parked (park_vec[g])
    );
  end

  barrel_pick #(.N(NTHREADS), .TID_W(TID_W)) u_pick (
    .elig  (ready_vec),
    .start (start_q),
    .found (sel_valid),
    .pick  (sel_tid)
  );

  always_comb begin
    start_d = (sel_tid == LAST_TID) ? '0 : sel_tid + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) start_q <= '0;
    else if (take)   start_q <= start_d;
  end
endmodule

// File: rtl/barrel_sel_chk.sv
module barrel_sel_chk #(
  parameter int NTHREADS = 8,
  parameter int TID_W    = 3
) (
  input logic                clk,
  input logic                rst_core_n,
  input logic                issue_ack,
  input logic [NTHREADS-1:0] mem_ret,
  input logic                sel_valid,
  input logic [TID_W-1:0]    sel_tid,
  input logic [NTHREADS-1:0] ready_vec,
  input logic [NTHREADS-1:0] park_vec,
  input logic [TID_W-1:0]    start_q
);
  AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sel_valid && issue_ack) |=> !(sel_valid && sel_tid == $past(sel_tid))); // R1

  AST_PICK_IS_READY: assert property (@(posedge clk) disable iff (!rst_core_n)
    sel_valid |-> ready_vec[sel_tid]); // R2

  AST_NO_FALSE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (|ready_vec) |-> sel_valid); // R2

  AST_START_STEP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sel_valid && issue_ack) |=>
      (start_q == (($past(sel_tid) == TID_W'(NTHREADS - 1)) ? '0 : $past(sel_tid) + 1'b1))); // R3

  AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(sel_valid && issue_ack) |=> $stable(start_q)); // R4

  for (genvar g = 0; g < NTHREADS; g++) begin : g_thr
    AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
      (park_vec[g] && !mem_ret[g]) |=> park_vec[g]); // R5

    AST_PARK_NOT_OFFERED: assert property (@(posedge clk) disable iff (!rst_core_n)
      park_vec[g] |-> !(sel_valid && sel_tid == TID_W'(g))); // R5
  end
endmodule

bind barrel_sel barrel_sel_chk #(.NTHREADS(NTHREADS), .TID_W(TID_W)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .issue_ack  (issue_ack),
  .mem_ret    (mem_ret),
  .sel_valid  (sel_valid),
  .sel_tid    (sel_tid),
  .ready_vec  (ready_vec),
  .park_vec   (park_vec),
  .start_q    (start_q)
);

// File: tb/barrel_sel_test.sv
module barrel_sel_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int TW = 3;
  localparam int WATCH_CYCLES = 20000;

  logic          clk;
  logic          rst_n;
  logic          issue_ack;
  logic [N-1:0]  done_pulse, park_req, mem_ret;
  logic          sel_valid;
  logic [TW-1:0] sel_tid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  barrel_sel #(.NTHREADS(N)) uut (
    .clk(clk), .rst_n(rst_n), .issue_ack(issue_ack),
    .done_pulse(done_pulse), .park_req(park_req), .mem_ret(mem_ret),
    .sel_valid(sel_valid), .sel_tid(sel_tid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCH_CYCLES) begin
      errors++;
      $display("FAIL watchdog: run exceeded %0d cycles (expected finish earlier)", WATCH_CYCLES);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; issue_ack = 1'b0;
    done_pulse = '0; park_req = '0; mem_ret = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Checks the offer of the current cycle, then applies this cycle's inputs.
  task automatic cyc(input logic ev, input int et, input logic ack,
                     input logic [N-1:0] dn, input logic [N-1:0] pk,
                     input logic [N-1:0] rt, input string req);
    #1;
    checks++;
    if (sel_valid !== ev || (ev && sel_tid !== TW'(et))) begin
      errors++;
      $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
               req, sel_valid, sel_tid, ev, ev ? et : 0);
    end
    issue_ack = ack; done_pulse = dn; park_req = pk; mem_ret = rt;
    @(posedge clk);
    @(negedge clk);
    issue_ack = 1'b0; done_pulse = '0; park_req = '0; mem_ret = '0;
  endtask

  task automatic test_rotation();
    do_reset();
    cyc(1, 0, 0, '0, '0, '0, "R7 reset offers thread 0");
    for (int i = 0; i < N; i++) cyc(1, i, 1, '0, '0, '0, "R3 revolution order");
    cyc(0, 0, 1, 8'h08, '0, '0, "R2 bubble with all in flight, R4 ack ignored");
    cyc(1, 3, 0, '0, '0, '0, "R6 completion visible one cycle later");
    cyc(1, 3, 1, '0, '0, '0, "R4 unaccepted offer repeats");
    cyc(0, 0, 0, 8'hFF, '0, '0, "R1 accepted thread not reoffered");
    cyc(1, 4, 1, '0, '0, '0, "R3 search starts after last accepted");
    cyc(1, 5, 0, '0, '0, '0, "R3 next in order");
  endtask

  task automatic test_parking();
    do_reset();
    cyc(1, 0, 1, '0, '0, '0, "R7 first offer");
    cyc(1, 1, 1, '0, 8'h01, '0, "R1 second offer while parking thread 0");
    cyc(1, 2, 1, 8'h01, '0, '0, "R5 completion to parked thread");
    cyc(1, 3, 1, 8'h02, 8'h02, '0, "R5 park and completion together");
    for (int i = 4; i < N; i++) cyc(1, i, 1, '0, '0, '0, "R1 remaining threads");
    cyc(0, 0, 0, '0, '0, 8'h01, "R5 parked thread not offered");
    cyc(1, 0, 1, '0, '0, '0, "R6 return visible next cycle, R3 wrap");
    cyc(0, 0, 0, '0, '0, 8'h02, "R5 park beat completion");
    cyc(1, 1, 0, '0, '0, '0, "R5 return readies thread 1");
  endtask

  task automatic test_ready_park();
    do_reset();
    cyc(1, 0, 0, '0, 8'h01, '0, "R5 park on ready thread");
    cyc(1, 0, 1, '0, '0, '0, "R5 park on ready thread ignored");
    cyc(1, 1, 1, '0, '0, '0, "R3 step after thread 0");
    cyc(1, 2, 0, 8'h01, '0, '0, "R4 hold with completion pending");
    cyc(1, 2, 1, '0, '0, '0, "R4 hold repeats offer");
    cyc(1, 3, 1, '0, '0, '0, "R3 order continues past ready thread 0");
  endtask

  initial begin
    test_rotation();
    test_parking();
    test_ready_park();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule